// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network DMA engine, reduced to the bookkeeping of descriptor ownership. It keeps a power-of-two ring of descriptors in an internal register file. Each entry holds a 4-bit ownership status and a frame length. A host port reads and writes any entry. Frames arrive as a beat stream with a valid strobe and an end-of-frame marker, and a frame's length is its number of beats. When a frame ends, the engine stores it in the descriptor under its current pointer, marks that descriptor full, and steps the pointer forward by one.

If the current descriptor is not empty when a frame must be stored, the engine halts and raises a sticky error interrupt. While it is halted, frames that arrive are kept in a small local hold buffer, and the frame that caused the stall is the first one kept. When that buffer fills, a separate RAM-full interrupt bit is set. After that, arriving frames are discarded and counted.

Software restarts the engine with a one-cycle strobe. The engine does not retry the descriptor it stalled on. It moves on to the next one, so the stalled entry is left as a hole in the ring. It then drains the held frames into descriptors, one per cycle, in the order they arrived. Frames that come in on the wire during the drain queue behind the held frames.

Top module: `rxring_dma_writer`

## Requirements
- R1: After reset, every descriptor reads status 0xF (not in use) with length 0. The current pointer is 0, the interrupt status is 0, the drop counter is 0 and the engine is not halted.
- R2: While running, a frame that ends on a descriptor with status 0xA (empty) writes status 0x4 (full) and the frame's beat count into that descriptor. The current pointer then advances by one, wrapping from the last entry to 0.
- R3: While running, a frame that ends on a descriptor whose status is not 0xA sets interrupt status bit 0 and sets `halted`. The descriptor and the current pointer are left unchanged.
- R4: The stalled frame and the frames that end while the engine is halted are held. After a restart they are written into consecutive descriptors in arrival order.
- R5: Interrupt status bit 1 is set in the cycle in which the hold buffer (HOLD_DEPTH frames) becomes full.
- R6: A restart strobe while halted moves the current pointer to the entry after the stalled descriptor. The stalled descriptor is never written by the drain.
- R7: `next_ptr` always equals `cur_ptr` plus one, modulo RING_DEPTH.
- R8: A frame that ends while the hold buffer is full, and is not freed by a pop in the same cycle, is discarded. `drop_count` is then incremented, saturating at its maximum value.
- R9: Interrupt status bits stay set until the host writes 1 to the matching bit of `irq_clr`. `irq` is the OR of the status bits.
- R10: A restart strobe while the engine is not halted has no effect.
- R11: During the drain, wire frames queue behind the held frames. If the drain reaches a descriptor that is not empty, the engine halts again and sets interrupt status bit 0.
- R12: A host write stores `host_wdata` as {status[3:0] in bits LEN_W+3..LEN_W, length in bits LEN_W-1..0} at `host_addr`. `host_rdata` shows the same layout for the entry at `host_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame beat present |
| in_last | input | 1 | Beat ends the frame |
| host_we | input | 1 | Host descriptor write |
| host_addr | input | log2(RING_DEPTH) | Host descriptor index |
| host_wdata | input | LEN_W+4 | Host write data {status, length} |
| host_rdata | output | LEN_W+4 | Descriptor at host_addr |
| restart | input | 1 | Restart strobe |
| irq_clr | input | 2 | Write-1-to-clear interrupt bits |
| irq_status | output | 2 | Bit 0 stall error, bit 1 hold buffer full |
| irq | output | 1 | Any interrupt status bit set |
| cur_ptr | output | log2(RING_DEPTH) | Hardware current descriptor |
| next_ptr | output | log2(RING_DEPTH) | Current descriptor plus one |
| halted | output | 1 | Engine stopped on a non-empty descriptor |
| drop_count | output | DROP_W | Saturating discarded-frame count |

## Verification
A wrong pointer or ownership decision inside the engine reaches the ports within one cycle. It shows as a mismatched `cur_ptr` or as a descriptor read back through the host port with the wrong status or length. A hold buffer that loses or reorders entries shows only later, when the drain writes lengths into the wrong descriptors after a restart. The bench therefore reads back every descriptor the drain touches, and it checks the hole left at the stalled entry.

// File: rtl/rxring_pkg.sv
// Shared codes and types for the receive descriptor ring writer.
package rxring_pkg;
    localparam logic [3:0] ST_EMPTY = 4'hA;
    localparam logic [3:0] ST_FULL  = 4'h4;
    localparam logic [3:0] ST_IDLE  = 4'hF;

    typedef enum logic [1:0] {
        ENG_RUN   = 2'd0,
        ENG_HALT  = 2'd1,
        ENG_DRAIN = 2'd2
    } eng_state_t;
endpackage

// File: rtl/rxring_desc_mem.sv
// Descriptor register file: one host read/write port and one engine
// read/write port. Both reads are combinational. When both ports write
// the same entry in the same cycle, the engine write wins.
// Assumes: indices are always in range (DEPTH is a power of two).
module rxring_desc_mem #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LEN_W + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_idx,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] eng_idx,
    output logic [3:0]    eng_status,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_wdata
);
    import rxring_pkg::*;

    logic [DW-1:0] mem [DEPTH];

    // Reset every entry to not-in-use, then apply host and engine writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= {ST_IDLE, {LEN_W{1'b0}}};
        end else begin
            if (host_we) mem[host_idx] <= host_wdata;
            if (eng_we)  mem[eng_idx]  <= eng_wdata;
        end
    end

    // Combinational read ports.
    always_comb begin
        host_rdata = mem[host_idx];
        eng_status = mem[eng_idx][DW-1:LEN_W];
    end
endmodule

// File: rtl/rxring_hold_fifo.sv
// Local hold buffer of frame lengths, first in first out. It accepts a
// push and a pop in the same cycle, even when full.
// Assumes: the caller never pops an empty buffer and never pushes into
// a full one without popping in the same cycle.
module rxring_hold_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Store pushed lengths.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    // Move the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Status flags and the head entry.
    always_comb begin
        dout  = slots[rd_ptr];
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end
endmodule

// File: rtl/rxring_beat_count.sv
// Counts the beats of the frame in progress and gives its length in the
// cycle of the end-of-frame beat. The length saturates at 2**LEN_W-1.
module rxring_beat_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             frame_done,
    output logic [LEN_W-1:0] frame_len
);
    localparam logic [LEN_W-1:0] LMAX = '1;

    logic [LEN_W-1:0] beats;

    // Count the beats before the last one; clear at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) beats <= '0;
        else if (in_valid) beats <= in_last ? '0 : ((beats == LMAX) ? LMAX : beats + 1'b1);
    end

    // The length includes the current (last) beat.
    always_comb begin
        frame_done = in_valid && in_last;
        frame_len  = (beats == LMAX) ? LMAX : beats + 1'b1;
    end
endmodule

// File: rtl/rxring_dma_writer.sv
// Receive descriptor ring writer. It stores each completed frame into
// the descriptor under the current pointer, halts on a non-empty
// descriptor, holds frames while halted, and drains them after a
// restart, starting one entry past the stalled descriptor.
// Assumes: RING_DEPTH is a power of two, so the pointer wraps by overflow.
module rxring_dma_writer #(
    parameter int RING_DEPTH = 16,
    parameter int LEN_W      = 8,
    parameter int HOLD_DEPTH = 4,
    parameter int DROP_W     = 4,
    localparam int PTR_W = $clog2(RING_DEPTH),
    localparam int DW    = LEN_W + 4,
    localparam int CW    = $clog2(HOLD_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              host_we,
    input  logic [PTR_W-1:0]  host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              restart,
    input  logic [1:0]        irq_clr,
    output logic [1:0]        irq_status,
    output logic              irq,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [PTR_W-1:0]  next_ptr,
    output logic              halted,
    output logic [DROP_W-1:0] drop_count
);
    import rxring_pkg::*;

    eng_state_t       state, nxt_state;
    logic             frame_done;
    logic [LEN_W-1:0] frame_len, hold_head, eng_len;
    logic [3:0]       cur_status;
    logic             eng_we, ptr_adv, push, pop, drop, set_err, set_full;
    logic             hold_full, hold_empty;
    logic [CW-1:0]    hold_count, cnt_next;

    rxring_beat_count #(.LEN_W(LEN_W)) u_beats (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .frame_done(frame_done), .frame_len(frame_len)
    );

    rxring_desc_mem #(.DEPTH(RING_DEPTH), .LEN_W(LEN_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_idx(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .eng_idx(cur_ptr), .eng_status(cur_status),
        .eng_we(eng_we), .eng_wdata({ST_FULL, eng_len})
    );

    rxring_hold_fifo #(.DEPTH(HOLD_DEPTH), .W(LEN_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .push(push), .din(frame_len), .pop(pop),
        .dout(hold_head), .count(hold_count), .full(hold_full), .empty(hold_empty)
    );

    // Engine decisions: store, halt, hold, drop, restart and drain.
    always_comb begin
        nxt_state = state;
        ptr_adv   = 1'b0;
        eng_we    = 1'b0;
        eng_len   = frame_len;
        push      = 1'b0;
        pop       = 1'b0;
        drop      = 1'b0;
        set_err   = 1'b0;
        case (state)
            ENG_RUN: begin
                if (frame_done) begin
                    if (cur_status == ST_EMPTY) begin
                        eng_we  = 1'b1;
                        ptr_adv = 1'b1;
                    end else begin
                        set_err   = 1'b1;
                        push      = 1'b1;
                        nxt_state = ENG_HALT;
                    end
                end
            end
            ENG_HALT: begin
                if (frame_done) begin
                    if (!hold_full) push = 1'b1;
                    else            drop = 1'b1;
                end
                if (restart) begin
                    ptr_adv   = 1'b1;
                    nxt_state = ENG_DRAIN;
                end
            end
            ENG_DRAIN: begin
                if (!hold_empty) begin
                    if (cur_status == ST_EMPTY) begin
                        eng_we  = 1'b1;
                        eng_len = hold_head;
                        pop     = 1'b1;
                        ptr_adv = 1'b1;
                    end else begin
                        set_err   = 1'b1;
                        nxt_state = ENG_HALT;
                    end
                end
                if (frame_done) begin
                    if (!hold_full || pop) push = 1'b1;
                    else                   drop = 1'b1;
                end
            end
            default: nxt_state = ENG_RUN;
        endcase
        cnt_next = hold_count + CW'(push) - CW'(pop);
        if (state == ENG_DRAIN && nxt_state == ENG_DRAIN && cnt_next == '0)
            nxt_state = ENG_RUN;
        set_full = push && (cnt_next == CW'(HOLD_DEPTH));
    end

    // State, pointer, sticky interrupts and saturating drop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENG_RUN;
            cur_ptr    <= '0;
            irq_status <= '0;
            drop_count <= '0;
        end else begin
            state      <= nxt_state;
            if (ptr_adv) cur_ptr <= cur_ptr + 1'b1;
            irq_status <= (irq_status & ~irq_clr) | {set_full, set_err};
            if (drop && drop_count != '1) drop_count <= drop_count + 1'b1;
        end
    end

    // Output views.
    always_comb begin
        next_ptr = cur_ptr + 1'b1;
        halted   = (state == ENG_HALT);
        irq      = |irq_status;
    end
endmodule

// File: rtl/rxring_dma_writer_chk.sv
// Temporal checks on the ring writer, bound to every instance.
module rxring_dma_writer_chk #(
    parameter int PTR_W  = 4,
    parameter int DROP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              halted,
    input logic [1:0]        irq_clr,
    input logic [1:0]        irq_status,
    input logic [PTR_W-1:0]  cur_ptr,
    input logic [DROP_W-1:0] drop_count
);
    // R2: the pointer moves only by single forward steps.
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ptr != $past(cur_ptr)) |-> (cur_ptr == PTR_W'($past(cur_ptr) + 1'b1)));

    // R3: entering the halted state always comes with the error bit.
    p_halt_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> irq_status[0]);

    // R6: a restart while halted skips to the following descriptor.
    p_restart_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && restart) |=> (cur_ptr == PTR_W'($past(cur_ptr) + 1'b1)));

    // R8: the drop counter only counts up by one.
    p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> (drop_count == DROP_W'($past(drop_count) + 1'b1)));

    // R9: error bit stays set unless cleared.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[0] && !irq_clr[0]) |=> irq_status[0]);

    // R9: RAM-full bit stays set unless cleared.
    p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[1] && !irq_clr[1]) |=> irq_status[1]);
endmodule

bind rxring_dma_writer rxring_dma_writer_chk #(.PTR_W(PTR_W), .DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .halted(halted),
    .irq_clr(irq_clr), .irq_status(irq_status), .cur_ptr(cur_ptr),
    .drop_count(drop_count)
);

// File: tb/sim_rxring_dma_writer.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module sim_rxring_dma_writer;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam int LEN_W = 8;
    localparam int HOLD  = 4;
    localparam int DROPW = 4;
    localparam int LMAX  = 255;
    localparam int DMAX  = 15;

    logic        clk = 0, rst_n = 0, in_valid = 0, in_last = 0, host_we = 0, restart = 0;
    logic [3:0]  host_addr = 0;
    logic [11:0] host_wdata = 0;
    logic [1:0]  irq_clr = 0;
    logic [11:0] host_rdata;
    logic [1:0]  irq_status;
    logic        irq, halted;
    logic [3:0]  cur_ptr, next_ptr;
    logic [3:0]  drop_count;

    int checks = 0, errors = 0, cycles = 0;

    rxring_dma_writer #(.RING_DEPTH(DEPTH), .LEN_W(LEN_W), .HOLD_DEPTH(HOLD), .DROP_W(DROPW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .restart(restart), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq(irq), .cur_ptr(cur_ptr), .next_ptr(next_ptr),
        .halted(halted), .drop_count(drop_count)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state.
    int mstat [DEPTH];
    int mlen  [DEPTH];
    int q [$];
    int mcur = 0, mstate = 0, mbeats = 0, mdrop = 0, mirq = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin mstat[i] = 15; mlen[i] = 0; end
            q.delete(); mcur = 0; mstate = 0; mbeats = 0; mdrop = 0; mirq = 0;
        end else begin
            automatic bit fd = in_valid && in_last;
            automatic int flen = (mbeats >= LMAX) ? LMAX : mbeats + 1;
            automatic bit ew = 0, adv = 0, pu = 0, po = 0, dr = 0, se = 0;
            automatic int elen = flen, nst = mstate, eidx = mcur;
            if (mstate == 0) begin
                if (fd) begin
                    if (mstat[mcur] == 10) begin ew = 1; adv = 1; end
                    else begin se = 1; pu = 1; nst = 1; end
                end
            end else if (mstate == 1) begin
                if (fd) begin if (q.size() < HOLD) pu = 1; else dr = 1; end
                if (restart) begin adv = 1; nst = 2; end
            end else begin
                if (q.size() > 0) begin
                    if (mstat[mcur] == 10) begin ew = 1; elen = q[0]; po = 1; adv = 1; end
                    else begin se = 1; nst = 1; end
                end
                if (fd) begin if (q.size() < HOLD || po) pu = 1; else dr = 1; end
            end
            if (po) void'(q.pop_front());
            if (pu) q.push_back(flen);
            if (mstate == 2 && nst == 2 && q.size() == 0) nst = 0;
            mirq = (mirq & ~int'(irq_clr)) | (se ? 1 : 0) | ((pu && q.size() == HOLD) ? 2 : 0);
            if (dr && mdrop < DMAX) mdrop++;
            if (in_valid) mbeats = in_last ? 0 : ((mbeats >= LMAX) ? LMAX : mbeats + 1);
            if (host_we) begin mstat[host_addr] = host_wdata[11:8]; mlen[host_addr] = host_wdata[7:0]; end
            if (ew) begin mstat[eidx] = 4; mlen[eidx] = elen; end
            if (adv) mcur = (mcur + 1) % DEPTH;
            mstate = nst;
        end
    end

    // Cycle-by-cycle comparison, a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            check("R2 cur_ptr", cur_ptr, mcur);
            check("R7 next_ptr", next_ptr, (mcur + 1) % DEPTH);
            check("R3 halted", halted, mstate == 1);
            check("R9 irq_status", irq_status, mirq);
            check("R9 irq", irq, mirq != 0);
            check("R8 drop_count", drop_count, mdrop);
            check("R12 rdata status", host_rdata[11:8], mstat[host_addr]);
            check("R12 rdata length", host_rdata[7:0], mlen[host_addr]);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); in_valid = 1; in_last = (i == n - 1);
        end
        @(negedge clk); in_valid = 0; in_last = 0;
    endtask

    task automatic hwrite(int a, int st, int ln);
        @(negedge clk); host_we = 1; host_addr = 4'(a); host_wdata = {4'(st), 8'(ln)};
        @(negedge clk); host_we = 0;
    endtask

    task automatic hread(int a, int st, int ln, string tag);
        @(negedge clk); host_addr = 4'(a);
        #(CLK_P/4);
        check({tag, " status"}, host_rdata[11:8], st);
        check({tag, " length"}, host_rdata[7:0], ln);
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart = 1;
        @(negedge clk); restart = 0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 2'b11;
        @(negedge clk); irq_clr = 2'b00;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #(CLK_P/4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        idle(1);
        check("R1 cur_ptr", cur_ptr, 0);
        check("R1 irq_status", irq_status, 0);
        check("R1 drop_count", drop_count, 0);
        for (int i = 0; i < DEPTH; i++) hread(i, 15, 0, "R1 desc");
        // R12: host writes make all entries empty
        for (int i = 0; i < DEPTH; i++) hwrite(i, 10, 0);
        hread(9, 10, 0, "R12 readback");
        // R10: restart while running
        pulse_restart();
        idle(1);
        check("R10 cur_ptr unchanged", cur_ptr, 0);
        check("R10 not halted", halted, 0);
        // R2: frames fill descriptors
        send(1); send(3); send(5);
        idle(1);
        hread(0, 4, 1, "R2 desc0");
        hread(1, 4, 3, "R2 desc1");
        hread(2, 4, 5, "R2 desc2");
        check("R2 cur_ptr", cur_ptr, 3);
        for (int i = 0; i < 13; i++) send(2);
        idle(1);
        check("R2 wrap cur_ptr", cur_ptr, 0);
        check("R7 next after wrap", next_ptr, 1);
        // R3: stall on full descriptor 0
        send(7);
        idle(1);
        check("R3 halted", halted, 1);
        check("R3 err bit", irq_status[0], 1);
        check("R3 ptr held", cur_ptr, 0);
        hread(0, 4, 1, "R3 desc0 untouched");
        // R5: hold buffer fills
        send(9); send(10);
        idle(1);
        check("R5 not yet full", irq_status[1], 0);
        send(11);
        idle(1);
        check("R5 ram full bit", irq_status[1], 1);
        // R8: drops saturate
        for (int i = 0; i < 17; i++) send(1);
        idle(1);
        check("R8 drop saturated", drop_count, DMAX);
        // R9: write-1-to-clear
        clear_irq();
        idle(1);
        check("R9 cleared", irq_status, 0);
        check("R9 irq low", irq, 0);
        // R6, R4, R11: restart and drain with a wire frame during the drain
        for (int i = 0; i < 6; i++) hwrite(i, 10, 0);
        pulse_restart();
        #(CLK_P/4);
        check("R6 resumes past stall", cur_ptr, 1);
        send(2);
        idle(4);
        hread(0, 10, 0, "R6 hole at stalled desc");
        hread(1, 4, 7, "R4 held frame 1");
        hread(2, 4, 9, "R4 held frame 2");
        hread(3, 4, 10, "R4 held frame 3");
        hread(4, 4, 11, "R4 held frame 4");
        hread(5, 4, 2, "R11 wire frame behind held");
        check("R11 running again", halted, 0);
        check("R2 cur after drain", cur_ptr, 6);
        // R11: re-halt during drain
        hwrite(7, 10, 0);
        send(3); send(5);
        clear_irq();
        pulse_restart();
        idle(3);
        hread(7, 4, 3, "R11 drained into 7");
        check("R11 re-halted", halted, 1);
        check("R11 err set again", irq_status[0], 1);
        check("R11 ptr at full desc", cur_ptr, 8);
        hread(8, 4, 2, "R11 desc8 untouched");
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule